// File: doc/BRIEF.md
# Clock Synthesizer Configuration Interface

This block holds the programming logic of a PLL frequency synthesizer. It keeps three registered fields. The 9-bit feedback multiplier `m` sets the VCO to 8·m times the reference after the reference has been divided by 16. The 2-bit post-divider code `n` selects an output division of 1, 2, 4 or 8. The 3-bit `t` code selects what the debug observation pin shows. So the synthesized frequency follows f_ref/16 · 8 · m / 2^n.

Values come from one of two paths. A three-wire serial port shifts a 14-bit word and commits it when its load strobe falls. A parallel pin bank is captured when its strobe rises. The parallel strobe also acts as a gate: while it is low, a serial commit may change only the test code. All control pins are oversampled in the `clk_i` domain through a synchronizer chain and edge-detected there. `clk_i` is the half-rate phase clock of the VCO. The block also holds the 50%-duty power-of-two post-divider, a divide-by-16 reference monitor and the test output multiplexer.

Top module: `cfg_synth_ctrl`

## Requirements
- R1: A level change on any control or data pin that is sampled at clock edge k acts at edge k+SYNC_STAGES. Outputs are read after that edge.
- R2: Each rising edge of `s_clk_i` shifts the synchronized `s_data_i` into bit 0 of a 14-bit register. The word is sent MSB first as t[2:0], then n[1:0], then m[8:0], so m[0] is the last bit.
- R3: A falling edge of `s_load_i` while `p_load_i` is high commits the whole shift register to `t_o`, `n_o` and `m_o`.
- R4: A falling edge of `s_load_i` while `p_load_i` is low updates `t_o` only. `m_o` and `n_o` keep their values.
- R5: A rising edge of `p_load_i` captures `p_m_i` into `m_o` and `p_n_i` into `n_o`. `t_o` is unchanged.
- R6: When a serial commit and a parallel capture happen on the same edge, `m_o` and `n_o` take the parallel values and `t_o` takes the serial value.
- R7: `post_clk_o` toggles every 2^n cycles of `clk_i`, so it is high for 2^n cycles and low for 2^n cycles. The encoding is n=0 for ÷1, 1 for ÷2, 2 for ÷4 and 3 for ÷8.
- R8: On the edge where `n_o` takes a new value, the post-divider restarts with `post_clk_o` low.
- R9: The reference monitor is a divide-by-REF_DIV clock that is high for the second half of each period after reset.
- R10: `test_o` shows the following: t=000 drives it low; t=001 shows the shift-register MSB; t=010 shows the reference monitor; t=011 shows `post_clk_o`; t=1xx drives it low.
- R11: After reset, `m_o`, `n_o` and `t_o` are zero and `test_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Half-rate VCO phase clock; the sampling clock for all logic |
| rst_ni | input | 1 | Active-low asynchronous reset |
| s_clk_i | input | 1 | Serial shift clock, sampled |
| s_data_i | input | 1 | Serial data bit |
| s_load_i | input | 1 | Serial commit strobe, acts on its falling edge |
| p_load_i | input | 1 | Parallel capture strobe, acts on its rising edge; low blocks serial m/n |
| p_m_i | input | 9 | Parallel multiplier value |
| p_n_i | input | 2 | Parallel post-divider code |
| m_o | output | 9 | Registered feedback multiplier |
| n_o | output | 2 | Registered post-divider code |
| t_o | output | 3 | Registered test-select code |
| post_clk_o | output | 1 | Post-divided clock, 50% duty |
| test_o | output | 1 | Selected observation signal |

## Verification
The bench builds the block with SYNC_STAGES=2 and REF_DIV=16. These values keep the latency from pin to register at two edges and the reference monitor period at 16 cycles, so a run of a few thousand cycles covers all four divide ratios, several full reference periods and both orders of the two strobes. A behavioural model that tracks delayed input history is compared with every output on every cycle. It is backed by directed checks on the priority gate, on a serial commit and a parallel capture landing on the same edge, and on high and low run lengths measured from each divided clock.

// File: rtl/cfgsyn_pkg.sv
package cfgsyn_pkg;
  localparam int M_W  = 9;
  localparam int N_W  = 2;
  localparam int T_W  = 3;
  localparam int SR_W = T_W + N_W + M_W;

  typedef struct packed {
    logic [T_W-1:0] t;
    logic [N_W-1:0] n;
    logic [M_W-1:0] m;
  } cfg_t;

  typedef enum logic [T_W-1:0] {
    TS_OFF   = 3'd0,
    TS_SHIFT = 3'd1,
    TS_REF   = 3'd2,
    TS_POST  = 3'd3
  } test_sel_e;
endpackage

// File: rtl/cfgsyn_sync.sv
module cfgsyn_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] q_prev_o
);
  // STAGES synchronizer flops plus one history flop for edge detection
  logic [STAGES:0][W-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q[0] <= d_i;
      for (int i = 1; i <= STAGES; i++) chain_q[i] <= chain_q[i-1];
    end
  end

  assign q_o      = chain_q[STAGES-1];
  assign q_prev_o = chain_q[STAGES];
endmodule

// File: rtl/cfgsyn_shift.sv
module cfgsyn_shift #(
  parameter int W = 14
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] word_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      word_o <= '0;
    else if (shift_i) word_o <= {word_o[W-2:0], bit_i};
  end
endmodule

// File: rtl/cfgsyn_postdiv.sv
module cfgsyn_postdiv #(
  parameter int CODE_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restart_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              clk_o
);
  localparam int MAX_HALF = 1 << ((1 << CODE_W) - 1);
  localparam int CNT_W    = (MAX_HALF > 1) ? $clog2(MAX_HALF) : 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   half;
  logic             wrap;

  assign half = (CNT_W+1)'(1) << code_i;
  assign wrap = (cnt_q == CNT_W'(half - 1'b1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      clk_o <= 1'b0;
    end else if (restart_i) begin
      cnt_q <= '0;
      clk_o <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      clk_o <= ~clk_o;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/cfgsyn_refdiv.sv
module cfgsyn_refdiv #(
  parameter int DIV = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic clk_o
);
  localparam int REF_W = (DIV > 1) ? $clog2(DIV) : 1;

  logic [REF_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  assign clk_o = cnt_q[REF_W-1];
endmodule

// File: rtl/cfg_synth_ctrl.sv
module cfg_synth_ctrl
  import cfgsyn_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int REF_DIV     = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           s_clk_i,
  input  logic           s_data_i,
  input  logic           s_load_i,
  input  logic           p_load_i,
  input  logic [M_W-1:0] p_m_i,
  input  logic [N_W-1:0] p_n_i,
  output logic [M_W-1:0] m_o,
  output logic [N_W-1:0] n_o,
  output logic [T_W-1:0] t_o,
  output logic           post_clk_o,
  output logic           test_o
);
  localparam int BW = 4 + M_W + N_W;

  logic [BW-1:0] raw, sy, pv;
  logic          s_rise, s_fall, p_rise, p_lvl, d_sync;
  logic [M_W-1:0] m_sync;
  logic [N_W-1:0] n_sync;
  logic [SR_W-1:0] sr_q;
  logic          ref_clk;
  logic          restart;
  cfg_t          cfg_q, cfg_d;

  assign raw = {s_clk_i, s_data_i, s_load_i, p_load_i, p_m_i, p_n_i};

  cfgsyn_sync #(.W(BW), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(raw), .q_o(sy), .q_prev_o(pv)
  );

  assign s_rise = sy[BW-1] & ~pv[BW-1];
  assign d_sync = sy[BW-2];
  assign s_fall = ~sy[BW-3] & pv[BW-3];
  assign p_lvl  = sy[BW-4];
  assign p_rise = sy[BW-4] & ~pv[BW-4];
  assign m_sync = sy[N_W +: M_W];
  assign n_sync = sy[N_W-1:0];

  cfgsyn_shift #(.W(SR_W)) u_shift (
    .clk_i, .rst_ni, .shift_i(s_rise), .bit_i(d_sync), .word_o(sr_q)
  );

  // parallel path overrides serial m/n; serial m/n gated by parallel strobe level
  always_comb begin
    cfg_d = cfg_q;
    if (s_fall) begin
      cfg_d.t = sr_q[SR_W-1 -: T_W];
      if (p_lvl) begin
        cfg_d.n = sr_q[M_W +: N_W];
        cfg_d.m = sr_q[M_W-1:0];
      end
    end
    if (p_rise) begin
      cfg_d.n = n_sync;
      cfg_d.m = m_sync;
    end
  end

  assign restart = (cfg_d.n != cfg_q.n);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else         cfg_q <= cfg_d;
  end

  cfgsyn_postdiv #(.CODE_W(N_W)) u_postdiv (
    .clk_i, .rst_ni, .restart_i(restart), .code_i(cfg_q.n), .clk_o(post_clk_o)
  );

  cfgsyn_refdiv #(.DIV(REF_DIV)) u_refdiv (
    .clk_i, .rst_ni, .clk_o(ref_clk)
  );

  always_comb begin
    case (test_sel_e'(cfg_q.t))
      TS_SHIFT: test_o = sr_q[SR_W-1];
      TS_REF:   test_o = ref_clk;
      TS_POST:  test_o = post_clk_o;
      default:  test_o = 1'b0;
    endcase
  end

  assign m_o = cfg_q.m;
  assign n_o = cfg_q.n;
  assign t_o = cfg_q.t;
endmodule

// File: rtl/cfg_synth_ctrl_chk.sv
module cfg_synth_ctrl_chk
  import cfgsyn_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            s_rise,
  input logic            s_fall,
  input logic            p_rise,
  input logic            p_lvl,
  input logic            d_sync,
  input logic [M_W-1:0]  m_sync,
  input logic [N_W-1:0]  n_sync,
  input logic [SR_W-1:0] sr_q,
  input logic [M_W-1:0]  m_o,
  input logic [N_W-1:0]  n_o,
  input logic [T_W-1:0]  t_o,
  input logic            post_clk_o,
  input logic            test_o
);
  AST_SHIFT_IN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_rise |=> sr_q[0] == $past(d_sync)); // R2
  AST_SER_T_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_fall |=> t_o == $past(sr_q[SR_W-1 -: T_W])); // R3
  AST_T_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !s_fall |=> $stable(t_o)); // R5
  AST_MN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(p_rise || (s_fall && p_lvl)) |=> $stable({m_o, n_o})); // R4
  AST_PAR_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    p_rise |=> (m_o == $past(m_sync)) && (n_o == $past(n_sync))); // R6
  AST_DIV_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (n_o != $past(n_o)) |-> !post_clk_o); // R8
  AST_TEST_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (t_o == 3'd0 || t_o[2]) |-> !test_o); // R10
endmodule

bind cfg_synth_ctrl cfg_synth_ctrl_chk u_chk (
  .clk_i, .rst_ni, .s_rise, .s_fall, .p_rise, .p_lvl, .d_sync,
  .m_sync, .n_sync, .sr_q, .m_o, .n_o, .t_o, .post_clk_o, .test_o
);

// File: tb/test_cfg_synth_ctrl.sv
module test_cfg_synth_ctrl;
  localparam int S = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       s_clk = 1'b0, s_data = 1'b0, s_load = 1'b0, p_load = 1'b0;
  logic [8:0] p_m = '0;
  logic [1:0] p_n = '0;
  logic [8:0] m_o;
  logic [1:0] n_o;
  logic [2:0] t_o;
  logic       post_clk_o, test_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cfg_synth_ctrl #(.SYNC_STAGES(S), .REF_DIV(16)) i_cfg_synth_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .s_clk_i(s_clk), .s_data_i(s_data),
    .s_load_i(s_load), .p_load_i(p_load), .p_m_i(p_m), .p_n_i(p_n),
    .m_o, .n_o, .t_o, .post_clk_o, .test_o
  );

  // behavioural reference model: input history bundle {sclk,sdata,sload,pload,pm,pn}
  logic [14:0] hist [0:S];
  int         md_m, md_n, md_t, md_cnt, md_ref;
  logic [13:0] md_sr;
  bit         md_div;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i <= S; i++) hist[i] = '0;
      md_m = 0; md_n = 0; md_t = 0; md_cnt = 0; md_ref = 0;
      md_sr = '0; md_div = 1'b0;
    end else begin
      logic [14:0] nw, od;
      int nn, half;
      nw = hist[S-1];
      od = hist[S];
      nn = md_n;
      if (!nw[12] && od[12]) begin
        md_t = int'(md_sr[13:11]);
        if (nw[11]) begin
          nn = int'(md_sr[10:9]);
          md_m = int'(md_sr[8:0]);
        end
      end
      if (nw[11] && !od[11]) begin
        nn = int'(nw[1:0]);
        md_m = int'(nw[10:2]);
      end
      if (nw[14] && !od[14]) md_sr = {md_sr[12:0], nw[13]};
      half = 1 << md_n;
      if (nn != md_n) begin
        md_cnt = 0; md_div = 1'b0;
      end else if (md_cnt == half - 1) begin
        md_cnt = 0; md_div = !md_div;
      end else begin
        md_cnt++;
      end
      md_n = nn;
      md_ref = (md_ref + 1) % 16;
      for (int i = S; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = {s_clk, s_data, s_load, p_load, p_m, p_n};
    end
  end

  function automatic bit md_test();
    case (md_t)
      1: return md_sr[13];
      2: return md_ref >= 8;
      3: return md_div;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R1 model m_o", int'(m_o), md_m);
      check("R1 model n_o", int'(n_o), md_n);
      check("R1 model t_o", int'(t_o), md_t);
      check("R7 model post_clk_o", int'(post_clk_o), int'(md_div));
      check("R10 model test_o", int'(test_o), int'(md_test()));
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_word(input logic [13:0] w);
    for (int i = 13; i >= 0; i--) begin
      s_data = w[i];
      tick(S + 1);
      s_clk = 1'b1;
      tick(S + 1);
      s_clk = 1'b0;
    end
    tick(S + 1);
  endtask

  task automatic pulse_sload();
    s_load = 1'b1;
    tick(S + 1);
    s_load = 1'b0;
    tick(S + 2);
  endtask

  task automatic measure(input bit use_test, output int hi, output int lo);
    hi = 0; lo = 0;
    while ((use_test ? test_o : post_clk_o) !== 1'b0) tick(1);
    while ((use_test ? test_o : post_clk_o) === 1'b0) tick(1);
    while ((use_test ? test_o : post_clk_o) === 1'b1) begin hi++; tick(1); end
    while ((use_test ? test_o : post_clk_o) === 1'b0) begin lo++; tick(1); end
  endtask

  initial begin
    int hi, lo;
    p_m = 9'h1A5; p_n = 2'd2;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R11 reset state
    check("R11 m_o reset", int'(m_o), 0);
    check("R11 n_o reset", int'(n_o), 0);
    check("R11 t_o reset", int'(t_o), 0);
    check("R11 test_o reset", int'(test_o), 0);

    // R4: parallel strobe low -> serial commit only updates t
    send_word({3'd3, 2'd1, 9'h0F3});
    check("R10 test_o low for t=000 after shifting", int'(test_o), 0);
    pulse_sload();
    check("R4 t_o from serial", int'(t_o), 3);
    check("R4 m_o blocked", int'(m_o), 0);
    check("R4 n_o blocked", int'(n_o), 0);

    // R5 + R1: parallel capture on rising strobe, latency S edges
    p_load = 1'b1;
    tick(S);
    check("R1 m_o not yet captured", int'(m_o), 0);
    tick(1);
    check("R5 m_o parallel", int'(m_o), 9'h1A5);
    check("R5 n_o parallel", int'(n_o), 2);
    check("R5 t_o unchanged", int'(t_o), 3);
    tick(2);

    // R2 + R3: full serial commit with strobe high
    send_word({3'd1, 2'd3, 9'h155});
    pulse_sload();
    check("R3 m_o serial", int'(m_o), 9'h155);
    check("R3 n_o serial", int'(n_o), 3);
    check("R2 t_o field order", int'(t_o), 1);
    check("R10 t=001 shows sr MSB", int'(test_o), 0);
    s_data = 1'b0;
    for (int k = 0; k < 2; k++) begin
      tick(S + 1); s_clk = 1'b1; tick(S + 1); s_clk = 1'b0;
    end
    tick(S + 1);
    check("R2 sr MSB after two shifts is t[0]", int'(test_o), 1);

    // R6: serial commit and parallel capture on the same edge
    p_load = 1'b0;
    p_m = 9'h07E; p_n = 2'd1;
    tick(S + 2);
    send_word({3'd2, 2'd0, 9'h100});
    s_load = 1'b1;
    tick(S + 1);
    s_load = 1'b0;
    p_load = 1'b1;
    tick(S + 3);
    check("R6 m_o parallel wins", int'(m_o), 9'h07E);
    check("R6 n_o parallel wins", int'(n_o), 1);
    check("R6 t_o from serial", int'(t_o), 2);

    // R9: reference monitor on test_o (t=010)
    measure(1'b1, hi, lo);
    check("R9 ref high run", hi, 8);
    check("R9 ref low run", lo, 8);

    // R7 + R8: every divide code
    for (int c = 0; c < 4; c++) begin
      p_load = 1'b0;
      tick(S + 2);
      p_n = 2'(c);
      p_m = 9'(40 + c);
      p_load = 1'b1;
      tick(S);
      tick(1);
      check("R8 n_o updated", int'(n_o), c);
      if (c != 1) check("R8 post_clk_o low at restart", int'(post_clk_o), 0);
      measure(1'b0, hi, lo);
      check("R7 post_clk high run", hi, 1 << c);
      check("R7 post_clk low run", lo, 1 << c);
    end

    // R10: t=011 shows post-divider, t=1xx low
    send_word({3'd3, 2'd3, 9'h040});
    pulse_sload();
    check("R10 t_o=3", int'(t_o), 3);
    tick(1);
    check("R10 test_o follows post_clk", int'(test_o), int'(post_clk_o));
    send_word({3'd5, 2'd3, 9'h040});
    pulse_sload();
    for (int k = 0; k < 20; k++) begin
      if (test_o !== 1'b0) begin
        check("R10 test_o low for t=1xx", int'(test_o), 0);
        break;
      end
      tick(1);
    end
    check("R10 t_o=5", int'(t_o), 5);

    tick(4);
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #1_500_000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule